// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral on a simple single-cycle register bus. Software programs a reload value and a control word. While the timer is enabled, the input clock passes through an 8-bit programmable prescaler. It then passes through a fixed power-of-two divider chosen from four settings. Each resulting tick decrements a live 16-bit counter. Software keeps the system alive by writing a fresh value into the counter register before the counter runs out.

When a tick arrives while the counter already holds zero, the block has expired. The counter reloads from the reload register and begins the next period. On expiry the block can latch a level interrupt, emit a fixed-length system reset pulse, or do both, as the control word selects. An external mask input, synchronised into the clock domain, can veto the reset pulse without affecting the interrupt. The interrupt stays asserted until software writes a one to the clear register.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the reload and counter registers both read 0xFFFF, and irq_o and sys_rst_o are low.
- R2: The word offsets are 0x0 for control, 0x4 for reload, 0x8 for the counter and 0xC for interrupt clear. Reads return the stored value zero-extended. The control register keeps only bits 15:8, 5:2 and 0, so bits 1, 6 and 7 read 0. The clear register reads 0.
- R3: The tick period is (P+1)*D input clocks. P is control bits 15:8. D is selected by control bits 4:3: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 128. The counter decrements once per tick.
- R4: A bus write to offset 0x8 loads bits 15:0 into the counter on that clock edge. It takes precedence over a tick on the same edge, so repeated writes keep the block from expiring.
- R5: A tick that finds the counter at zero is an expiry. On the same edge the counter reloads from the reload register.
- R6: If control bit 2 is set, an expiry raises irq_o on the next cycle. irq_o then stays high until a write to offset 0xC with bit 0 set. If a set and a clear arrive on the same edge, the set wins.
- R7: If control bit 0 is set and the synchronised mask is low, an expiry drives sys_rst_o high for exactly 16 clock cycles.
- R8: While rst_mask_i is high, which is seen through a two-stage synchroniser, an expiry produces no reset pulse but still sets irq_o when bit 2 is set.
- R9: While control bit 5 is low, the counter holds its value and the prescaler and divider are cleared. The first tick after enabling therefore comes a full period later.
- R10: A write to offset 0xC with bit 0 clear has no effect on irq_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| rst_mask_i | input | 1 | Asynchronous veto of the reset pulse |
| irq_o | output | 1 | Sticky expiry interrupt |
| sys_rst_o | output | 1 | Fixed-length reset pulse |

## Verification
The tick chain is run with three prescale and divide pairs: P=1 with D=16, P=0 with D=128, and P=2 with D=64. Sampling one cycle before and one cycle after each expected decrement shows whether the prescaler and the divider select each take effect, and whether either is off by one. A disable partway through a period, followed by a re-enable, separates a cleared prescaler from one that keeps its stale phase. Expiry runs with the mask low and with the mask high tell apart the interrupt path and the reset path. Clear writes with bit 0 low and with bit 0 high check that the sticky interrupt is released only by the intended write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned OFS_CTRL = 4'h0;
   localparam int unsigned OFS_DATA = 4'h4;
   localparam int unsigned OFS_CNT  = 4'h8;
   localparam int unsigned OFS_CLR  = 4'hC;

   // writable bits of the control word: 15:8 prescale, 5 run, 4:3 select, 2 irq, 0 reset
   localparam logic [15:0] CTRL_KEEP = 16'hFF3D;

   typedef struct packed {
      logic [7:0] pre;
      logic [1:0] sel;
      logic       run;
      logic       irq_en;
      logic       rst_en;
   } ctrl_t;

   function automatic ctrl_t split_ctrl(input logic [15:0] w);
      ctrl_t c;
      c.pre    = w[15:8];
      c.sel    = w[4:3];
      c.run    = w[5];
      c.irq_en = w[2];
      c.rst_en = w[0];
      return c;
   endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_q,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  reload,
   output logic              cnt_wr,
   output logic [CNT_W-1:0]  cnt_wval,
   output logic              clr_pulse,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [CNT_W-1:0] CNT_INIT = '1;

   logic        wr;
   logic        hit_ctrl, hit_data, hit_cnt, hit_clr;
   logic [15:0] ctrl_q;
   logic [CNT_W-1:0] data_q;

   assign wr       = bus_en && bus_we;
   assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT));
   assign hit_clr  = (bus_addr == ADDR_W'(OFS_CLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         data_q <= CNT_INIT;
      end else if (wr) begin
         if (hit_ctrl) ctrl_q <= bus_wdata[15:0] & CTRL_KEEP;
         if (hit_data) data_q <= bus_wdata[CNT_W-1:0];
      end
   end

   assign ctrl      = split_ctrl(ctrl_q);
   assign reload    = data_q;
   assign cnt_wr    = wr && hit_cnt;
   assign cnt_wval  = bus_wdata[CNT_W-1:0];
   assign clr_pulse = wr && hit_clr && bus_wdata[0];

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl)      bus_rdata = DATA_W'(ctrl_q);
      else if (hit_data) bus_rdata = DATA_W'(data_q);
      else if (hit_cnt)  bus_rdata = DATA_W'(cnt_q);
   end

   logic unused_bits;
   assign unused_bits = ^{bus_wdata, ctrl_q[7:6], ctrl_q[1]};

   // R2: a control write keeps none of the reserved bits
   a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit_ctrl) |=> (ctrl_q[7:6] == 2'b00 && ctrl_q[1] == 1'b0));
endmodule

// File: rtl/wdog_tickgen.sv
module wdog_tickgen #(
   parameter int unsigned PRE_W     = 8,
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned BASE_LOG2 = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int unsigned DIV_W = BASE_LOG2 + (1 << SEL_W) - 1;

   generate
      if (PRE_W < 1 || SEL_W < 1 || SEL_W > 3 || BASE_LOG2 < 1) begin : g_bad_cfg
         $error("wdog_tickgen: unsupported parameter set");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_lim;
   logic             pre_wrap, div_wrap;

   assign div_lim  = (DIV_W'(1) << (BASE_LOG2 + 32'(sel))) - DIV_W'(1);
   assign pre_wrap = (pre_q >= pre);
   assign div_wrap = (div_q >= div_lim);
   assign tick     = run && pre_wrap && div_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         div_q <= '0;
      end else if (!run) begin
         pre_q <= '0;
         div_q <= '0;
      end else if (pre_wrap) begin
         pre_q <= '0;
         div_q <= div_wrap ? '0 : div_q + DIV_W'(1);
      end else begin
         pre_q <= pre_q + PRE_W'(1);
      end
   end

   // R9: the stages restart from zero whenever the timer is stopped
   a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pre_q == '0 && div_q == '0));
   // R3: a tick never follows a tick on the next cycle, since every period is at least 2 clocks
   a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run) |=> !tick);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wval,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire
);
   localparam logic [CNT_W-1:0] CNT_INIT = '1;

   logic at_zero;
   assign at_zero = (cnt_q == '0);
   assign expire  = tick && !cnt_wr && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= CNT_INIT;
      else if (cnt_wr) cnt_q <= cnt_wval;
      else if (tick)   cnt_q <= at_zero ? reload : cnt_q - CNT_W'(1);
   end

   // R4: a write lands in the counter on the next cycle, whatever the tick does
   a_r4_keepalive_load: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(cnt_wval)));
   // R5: an expiry reloads from the reload register
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt_q == $past(reload)));
   // R9: without a tick or a write the counter does not move
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_action.sv
module wdog_action #(
   parameter int unsigned RST_LEN   = 16,
   parameter bit          SYNC_MASK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic irq_en,
   input  logic rst_en,
   input  logic clr_pulse,
   input  logic mask_in,
   output logic irq_o,
   output logic rst_o
);
   localparam int unsigned RW = $clog2(RST_LEN + 1);

   generate
      if (RST_LEN < 1) begin : g_bad_len
         $error("wdog_action: RST_LEN must be at least 1");
      end
   endgenerate

   logic mask_eff;

   generate
      if (SYNC_MASK) begin : g_sync
         logic s1, s2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1 <= 1'b0;
               s2 <= 1'b0;
            end else begin
               s1 <= mask_in;
               s2 <= s1;
            end
         end
         assign mask_eff = s2;
      end else begin : g_direct
         assign mask_eff = mask_in;
      end
   endgenerate

   logic [RW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               left_q <= '0;
      else if (expire && rst_en && !mask_eff)   left_q <= RW'(RST_LEN);
      else if (left_q != '0)                    left_q <= left_q - RW'(1);
   end
   assign rst_o = (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 irq_o <= 1'b0;
      else if (expire && irq_en)  irq_o <= 1'b1;
      else if (clr_pulse)         irq_o <= 1'b0;
   end

   // checker state: length of the current reset pulse, saturating
   logic [RW-1:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                hi_len <= '0;
      else if (!rst_o)                           hi_len <= '0;
      else if (hi_len < RW'(RST_LEN))            hi_len <= hi_len + RW'(1);
   end

   // R7: every reset pulse lasts at least RST_LEN cycles
   a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_o) |-> (hi_len == RW'(RST_LEN)));
   // R8: a pulse starts only while the mask was low
   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_o) |-> !$past(mask_eff));
   // R6: interrupt is raised by an enabled expiry
   a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && irq_en) |=> irq_o);
   // R6 / R10: interrupt only falls on a clear write
   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_pulse) |=> irq_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned RST_LEN   = 16,
   parameter bit          SYNC_MASK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rst_mask_i,
   output logic              irq_o,
   output logic              sys_rst_o
);
   localparam int unsigned PRE_W     = 8;
   localparam int unsigned SEL_W     = 2;
   localparam int unsigned BASE_LOG2 = 4;

   generate
      if (ADDR_W < 4 || DATA_W < 16 || CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cfg
         $error("wdog_timer: unsupported parameter set");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] reload, cnt_q, cnt_wval;
   logic             cnt_wr, clr_pulse, tick, expire;

   wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cnt_q     (cnt_q),
      .ctrl      (ctrl),
      .reload    (reload),
      .cnt_wr    (cnt_wr),
      .cnt_wval  (cnt_wval),
      .clr_pulse (clr_pulse),
      .bus_rdata (bus_rdata)
   );

   wdog_tickgen #(.PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl.run),
      .pre   (ctrl.pre),
      .sel   (ctrl.sel),
      .tick  (tick)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt_wr   (cnt_wr),
      .cnt_wval (cnt_wval),
      .reload   (reload),
      .cnt_q    (cnt_q),
      .expire   (expire)
   );

   wdog_action #(.RST_LEN(RST_LEN), .SYNC_MASK(SYNC_MASK)) u_act (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .irq_en    (ctrl.irq_en),
      .rst_en    (ctrl.rst_en),
      .clr_pulse (clr_pulse),
      .mask_in   (rst_mask_i),
      .irq_o     (irq_o),
      .rst_o     (sys_rst_o)
   );

   // R9: the counter cannot expire while the timer is stopped
   a_r9_no_fire_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.run |-> !expire);
   // R1: outputs quiet in the first cycle out of reset
   a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && !sys_rst_o));
endmodule

// File: tb/wdog_timer_test.sv
`timescale 1ns/100ps
module wdog_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        rst_mask_i = 1'b0;
   logic        irq_o, sys_rst_o;

   always #2 clk = ~clk;

   wdog_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_mask_i(rst_mask_i), .irq_o(irq_o), .sys_rst_o(sys_rst_o));

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [15:0] m_ctrl, m_data, m_cnt;
   int          m_ph, m_left;
   bit          m_irq, m_s1, m_s2;

   always @(posedge clk) begin : model
      bit en, wr, tk, ex;
      int per;
      if (!rst_n) begin
         m_ctrl = 16'h0; m_data = 16'hFFFF; m_cnt = 16'hFFFF;
         m_ph = 0; m_left = 0; m_irq = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         en  = m_ctrl[5];
         per = (int'(m_ctrl[15:8]) + 1) * (16 << int'(m_ctrl[4:3]));
         wr  = bus_en && bus_we;
         tk  = en && (m_ph == per - 1);
         ex  = tk && (m_cnt == 16'h0) && !(wr && bus_addr == 4'h8);
         m_ph = en ? (tk ? 0 : m_ph + 1) : 0;
         if (wr && bus_addr == 4'h8) m_cnt = bus_wdata[15:0];
         else if (tk) m_cnt = (m_cnt == 16'h0) ? m_data : m_cnt - 16'h1;
         if (ex && m_ctrl[0] && !m_s2) m_left = 16;
         else if (m_left > 0) m_left--;
         if (ex && m_ctrl[2]) m_irq = 1;
         else if (wr && bus_addr == 4'hC && bus_wdata[0]) m_irq = 0;
         m_s2 = m_s1;
         m_s1 = rst_mask_i;
         if (wr && bus_addr == 4'h0) m_ctrl = bus_wdata[15:0] & 16'hFF3D;
         if (wr && bus_addr == 4'h4) m_data = bus_wdata[15:0];
      end
   end

   function automatic logic [31:0] m_read(input logic [3:0] a);
      case (a)
         4'h0:    return {16'h0, m_ctrl};
         4'h4:    return {16'h0, m_data};
         4'h8:    return {16'h0, m_cnt};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin : monitor
      #1;
      if (rst_n) begin
         chk("R6 irq vs model", {31'h0, irq_o}, {31'h0, m_irq});
         chk("R7 sys_rst vs model", {31'h0, sys_rst_o}, {31'h0, (m_left > 0)});
         chk("R2 rdata vs model", bus_rdata, m_read(bus_addr));
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic peek(input logic [3:0] a, input string tag, input logic [31:0] exp);
      bus_addr = a;
      #0.2;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic after(input int n);
      repeat (n) @(posedge clk);
      #1.2;
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin : main
      int seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(4'h0, "R1 control after reset", 32'h0);
      peek(4'h4, "R1 reload after reset", 32'hFFFF);
      peek(4'h8, "R1 counter after reset", 32'hFFFF);
      chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);
      chk("R1 sys_rst after reset", {31'h0, sys_rst_o}, 32'h0);
      peek(4'hC, "R2 clear register reads zero", 32'h0);

      // R2 masking and readback
      wr(4'h0, 32'hFFFF_FFDF);
      peek(4'h0, "R2 control keeps writable bits", 32'h0000_FF1D);
      wr(4'h0, 32'h0);
      wr(4'h4, 32'h0000_1234);
      peek(4'h4, "R2 reload readback", 32'h1234);

      // R3 P=1, D=16 -> 32 clocks
      wr(4'h4, 32'h3);
      wr(4'h8, 32'h3);
      wr(4'h0, 32'h0120);
      bus_addr = 4'h8;
      after(31); chk("R3 P1 D16 before tick", bus_rdata, 32'h3);
      after(1);  chk("R3 P1 D16 at tick", bus_rdata, 32'h2);

      // R3 P=0, D=128 -> 128 clocks
      wr(4'h0, 32'h0);
      wr(4'h8, 32'h5);
      wr(4'h0, 32'h0038);
      bus_addr = 4'h8;
      after(127); chk("R3 P0 D128 before tick", bus_rdata, 32'h5);
      after(1);   chk("R3 P0 D128 at tick", bus_rdata, 32'h4);

      // R3 P=2, D=64 -> 192 clocks
      wr(4'h0, 32'h0);
      wr(4'h8, 32'h5);
      wr(4'h0, 32'h0230);
      bus_addr = 4'h8;
      after(191); chk("R3 P2 D64 before tick", bus_rdata, 32'h5);
      after(1);   chk("R3 P2 D64 at tick", bus_rdata, 32'h4);

      // R9 stop mid-period, hold, restart with full period
      wr(4'h0, 32'h0);
      wr(4'h8, 32'h7);
      wr(4'h0, 32'h0020);
      bus_addr = 4'h8;
      after(20); chk("R9 running decrement", bus_rdata, 32'h6);
      wr(4'h0, 32'h0);
      bus_addr = 4'h8;
      after(100); chk("R9 counter held while stopped", bus_rdata, 32'h6);
      wr(4'h0, 32'h0020);
      bus_addr = 4'h8;
      after(15); chk("R9 no early tick after restart", bus_rdata, 32'h6);
      after(1);  chk("R9 full period after restart", bus_rdata, 32'h5);

      // R4 immediate load and keepalive
      wr(4'h8, 32'h0ABC);
      peek(4'h8, "R4 counter write visible next cycle", 32'h0ABC);
      wr(4'h0, 32'h0024);
      for (int i = 0; i < 6; i++) begin
         wr(4'h8, 32'h2);
         repeat (20) @(negedge clk);
      end
      chk("R4 keepalive prevents expiry", {31'h0, irq_o}, 32'h0);
      wr(4'h0, 32'h0);

      // R5 R6 R7 expiry with interrupt and reset
      wr(4'h4, 32'h2);
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h0025);
      bus_addr = 4'h8;
      after(15);
      chk("R6 no irq before expiry", {31'h0, irq_o}, 32'h0);
      chk("R5 counter at zero before expiry", bus_rdata, 32'h0);
      after(1);
      chk("R6 irq on expiry", {31'h0, irq_o}, 32'h1);
      chk("R7 reset pulse starts", {31'h0, sys_rst_o}, 32'h1);
      chk("R5 reload on expiry", bus_rdata, 32'h2);
      after(15); chk("R7 reset pulse last cycle", {31'h0, sys_rst_o}, 32'h1);
      after(1);  chk("R7 reset pulse ended after 16", {31'h0, sys_rst_o}, 32'h0);
      wr(4'h0, 32'h0);

      // R10 clear with bit 0 low, then R6 clear
      wr(4'hC, 32'hFFFF_FFFE);
      chk("R10 clear without bit0 ignored", {31'h0, irq_o}, 32'h1);
      wr(4'hC, 32'h1);
      chk("R6 clear write releases irq", {31'h0, irq_o}, 32'h0);

      // R8 masked reset
      rst_mask_i = 1'b1;
      repeat (4) @(negedge clk);
      wr(4'h8, 32'h0);
      wr(4'h0, 32'h0025);
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         after(1);
         if (sys_rst_o) seen++;
      end
      chk("R8 no reset pulse while masked", seen, 0);
      chk("R8 irq still raised while masked", {31'h0, irq_o}, 32'h1);
      wr(4'h0, 32'h0);
      wr(4'hC, 32'h1);
      rst_mask_i = 1'b0;
      repeat (4) @(negedge clk);

      finish_run();
   end
endmodule